// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block turns one decoded block-transfer memory instruction into a serial stream of simple micro-operations for a downstream execution pipe. An instruction is taken over a valid/ready handshake. It carries five mode bits (pre/post indexing, up/down direction, a user-mode flag, base writeback, and load/store), a 4-bit base register index, and a 16-bit register list. The block then offers micro-ops one at a time on a second valid/ready handshake. Each micro-op has an opcode, a destination index, a source index, an offset magnitude, an offset-sign bit and a last flag.

The stream always has the same shape. First comes a copy of the base register into a scratch address register, index 17. Next comes one load or store for each register named in the list, lowest register first, each at an offset from the scratch address. An optional final micro-op moves the base register up or down by four times the register count. Instructions with the user-mode flag set are rejected: the block raises a one-cycle error flag and emits nothing.

Top module: `ldm_uop_seq`

## Requirements
- R1: After an instruction with in_user=0 is accepted, the first micro-op has opcode ADDI (code 0), destination 17, source equal to the base index, and imm 0.
- R2: With in_pre=0 and in_up=0, the first transfer uses imm 4n-4 with uop_neg=1, where n is the number of set bits in the register list.
- R3: With in_pre=0 and in_up=1, the first transfer uses imm 0 with uop_neg=0.
- R4: With in_pre=1 and in_up=0, the first transfer uses imm 4n with uop_neg=1.
- R5: With in_pre=1 and in_up=1, the first transfer uses imm 4 with uop_neg=0.
- R6: There is one transfer micro-op per set list bit, in ascending register order. Its opcode is LOAD (code 2) when in_load=1 and STORE (code 3) otherwise. Its destination is the register number and its source is 17.
- R7: Each later transfer's imm is the previous one plus 4 when in_up=1, or minus 4 when in_up=0.
- R8: When in_wb=1, a final micro-op has destination and source equal to the base index and imm 4n. Its opcode is ADDI (code 0) when in_up=1 and SUBI (code 1) when in_up=0.
- R9: An instruction yields exactly n+1+in_wb micro-ops. Only the final one has uop_last=1. Afterwards uop_valid is low and in_ready is high.
- R10: Accepting an instruction with in_user=1 raises err_mode for exactly one cycle. No micro-op is emitted for it.
- R11: An empty register list yields only the address copy, plus the writeback when in_wb=1. The copy carries uop_last when in_wb=0.
- R12: While uop_valid=1 and uop_ready=0, all micro-op fields stay stable. in_ready is low from acceptance until the last micro-op is transferred. Out of reset, uop_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, can take an instruction |
| in_pre | input | 1 | Adjust address before each transfer |
| in_up | input | 1 | Addresses ascend when 1 |
| in_user | input | 1 | User-mode flag; unsupported, causes rejection |
| in_wb | input | 1 | Update base register at end |
| in_load | input | 1 | 1 = load, 0 = store |
| in_base | input | 4 | Base register index |
| in_rlist | input | 16 | Register list bitmask |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_op | output | 2 | 0 ADDI, 1 SUBI, 2 LOAD, 3 STORE |
| uop_dst | output | 5 | Destination register index |
| uop_src | output | 5 | Source register index |
| uop_imm | output | 7 | Immediate or offset magnitude |
| uop_neg | output | 1 | Transfer offset is subtracted from address |
| uop_last | output | 1 | Final micro-op of the instruction |
| err_mode | output | 1 | One-cycle pulse: instruction rejected |

## Verification
The assertions check several properties on every cycle. They check that an accepted instruction always starts with the scratch-address copy, and that micro-op fields hold still under back-pressure. They check that no instruction is accepted while a stream is in flight, that consecutive transfers step by exactly four in the right direction, and that a rejected instruction produces no output. Other properties can only be shown by the bench's scenarios. These are the exact start offset for each of the four addressing modes, the ascending register order, the writeback amount, and the total count with its single last flag. The bench runs instructions with sparse, empty and full lists across every mode.

// File: rtl/ldm_uop_pkg.sv
package ldm_uop_pkg;

    typedef enum logic [1:0] {
        UOP_ADDI  = 2'd0,
        UOP_SUBI  = 2'd1,
        UOP_LOAD  = 2'd2,
        UOP_STORE = 2'd3
    } uop_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COPY  = 2'd1,
        PH_XFER  = 2'd2,
        PH_WBACK = 2'd3
    } phase_e;

endpackage

// File: rtl/ldm_popcnt.sv
module ldm_popcnt #(
    parameter int W     = 16,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ldm_lowbit.sv
module ldm_lowbit #(
    parameter int W    = 16,
    localparam int IW  = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the one left standing.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ldm_start_off.sv
module ldm_start_off #(
    parameter int CNT_W = 5,
    parameter int OFF_W = 7,
    parameter int STEP  = 4
) (
    input  logic             pre,
    input  logic             up,
    input  logic [CNT_W-1:0] cnt,
    output logic [OFF_W-1:0] off
);
    logic [OFF_W-1:0] span;

    assign span = OFF_W'(cnt) * OFF_W'(STEP);

    always_comb begin
        unique case ({pre, up})
            2'b00:   off = span - OFF_W'(STEP);  // descend, adjust after
            2'b01:   off = '0;                   // ascend, adjust after
            2'b10:   off = span;                 // descend, adjust before
            default: off = OFF_W'(STEP);         // ascend, adjust before
        endcase
    end
endmodule

// File: rtl/ldm_uop_seq.sv
module ldm_uop_seq
    import ldm_uop_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int IDX_W   = 5,
    parameter int TMP_IDX = 17,
    parameter int STEP    = 4,
    localparam int BASE_W = $clog2(NREG),
    localparam int CNT_W  = $clog2(NREG + 1),
    localparam int OFF_W  = $clog2(STEP * NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_pre,
    input  logic              in_up,
    input  logic              in_user,
    input  logic              in_wb,
    input  logic              in_load,
    input  logic [BASE_W-1:0] in_base,
    input  logic [NREG-1:0]   in_rlist,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [1:0]        uop_op,
    output logic [IDX_W-1:0]  uop_dst,
    output logic [IDX_W-1:0]  uop_src,
    output logic [OFF_W-1:0]  uop_imm,
    output logic              uop_neg,
    output logic              uop_last,
    output logic              err_mode
);

    typedef struct packed {
        phase_e            ph;
        logic [NREG-1:0]   rem;
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  cnt;
        logic [BASE_W-1:0] base;
        logic              up;
        logic              load;
        logic              wb;
        logic              err;
    } seq_t;

    seq_t seq_q, seq_d;

    logic [CNT_W-1:0]  in_cnt;
    logic [OFF_W-1:0]  in_off;
    logic              lo_found;
    logic [BASE_W-1:0] lo_idx;
    logic [NREG-1:0]   rem_after;
    logic              fire;

    ldm_popcnt #(.W(NREG)) u_popcnt (
        .vec (in_rlist),
        .cnt (in_cnt)
    );

    ldm_start_off #(.CNT_W(CNT_W), .OFF_W(OFF_W), .STEP(STEP)) u_start (
        .pre (in_pre),
        .up  (in_up),
        .cnt (in_cnt),
        .off (in_off)
    );

    ldm_lowbit #(.W(NREG)) u_lowbit (
        .vec   (seq_q.rem),
        .found (lo_found),
        .idx   (lo_idx)
    );

    assign rem_after = seq_q.rem & ~(NREG'(1) << lo_idx);
    assign in_ready  = (seq_q.ph == PH_IDLE);
    assign uop_valid = (seq_q.ph != PH_IDLE);
    assign fire      = uop_valid && uop_ready;
    assign err_mode  = seq_q.err;

    // Output fields depend only on registered state, so they hold under stall.
    always_comb begin
        uop_op   = UOP_ADDI;
        uop_dst  = '0;
        uop_src  = '0;
        uop_imm  = '0;
        uop_neg  = 1'b0;
        uop_last = 1'b0;
        unique case (seq_q.ph)
            PH_COPY: begin
                uop_op   = UOP_ADDI;
                uop_dst  = IDX_W'(TMP_IDX);
                uop_src  = IDX_W'(seq_q.base);
                uop_last = (seq_q.rem == '0) && !seq_q.wb;
            end
            PH_XFER: begin
                uop_op   = seq_q.load ? UOP_LOAD : UOP_STORE;
                uop_dst  = IDX_W'(lo_idx);
                uop_src  = IDX_W'(TMP_IDX);
                uop_imm  = seq_q.off;
                uop_neg  = !seq_q.up;
                uop_last = (rem_after == '0) && !seq_q.wb;
            end
            PH_WBACK: begin
                uop_op   = seq_q.up ? UOP_ADDI : UOP_SUBI;
                uop_dst  = IDX_W'(seq_q.base);
                uop_src  = IDX_W'(seq_q.base);
                uop_imm  = OFF_W'(seq_q.cnt) * OFF_W'(STEP);
                uop_last = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    if (in_user) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.ph   = PH_COPY;
                        seq_d.rem  = in_rlist;
                        seq_d.off  = in_off;
                        seq_d.cnt  = in_cnt;
                        seq_d.base = in_base;
                        seq_d.up   = in_up;
                        seq_d.load = in_load;
                        seq_d.wb   = in_wb;
                    end
                end
            end
            PH_COPY: begin
                if (fire) begin
                    if (seq_q.rem != '0)  seq_d.ph = PH_XFER;
                    else if (seq_q.wb)    seq_d.ph = PH_WBACK;
                    else                  seq_d.ph = PH_IDLE;
                end
            end
            PH_XFER: begin
                if (fire) begin
                    seq_d.rem = rem_after;
                    seq_d.off = seq_q.up ? seq_q.off + OFF_W'(STEP)
                                         : seq_q.off - OFF_W'(STEP);
                    if (rem_after != '0)  seq_d.ph = PH_XFER;
                    else if (seq_q.wb)    seq_d.ph = PH_WBACK;
                    else                  seq_d.ph = PH_IDLE;
                end
            end
            default: begin
                if (fire) seq_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.ph <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_FIRST_IS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_user |=> uop_valid && uop_op == 2'(UOP_ADDI)
        && uop_dst == IDX_W'(TMP_IDX) && uop_imm == '0); // R1

    AST_XFER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (uop_op == 2'(UOP_LOAD) || uop_op == 2'(UOP_STORE)) && !uop_last |=>
        !(uop_op == 2'(UOP_LOAD) || uop_op == 2'(UOP_STORE)) ||
        (uop_imm == ($past(uop_neg) ? OFF_W'($past(uop_imm) - OFF_W'(STEP))
                                    : OFF_W'($past(uop_imm) + OFF_W'(STEP))))); // R7

    AST_XFER_HAS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ph == PH_XFER |-> lo_found); // R6

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && uop_last |=> in_ready && !uop_valid); // R9

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_user |=> err_mode && !uop_valid); // R10

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |=> !err_mode || $past(in_valid && in_user)); // R10

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready); // R12

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_dst)
        && $stable(uop_src) && $stable(uop_imm) && $stable(uop_neg) && $stable(uop_last)); // R12

endmodule

// File: tb/ldm_uop_seq_tb.sv
`timescale 1ns/1ps
module ldm_uop_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_pre = 1'b0, in_up = 1'b0, in_user = 1'b0;
    logic        in_wb = 1'b0, in_load = 1'b0;
    logic [3:0]  in_base = '0;
    logic [15:0] in_rlist = '0;
    logic        uop_ready = 1'b1;
    logic        in_ready, uop_valid, uop_neg, uop_last, err_mode;
    logic [1:0]  uop_op;
    logic [4:0]  uop_dst, uop_src;
    logic [6:0]  uop_imm;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ldm_uop_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_pre(in_pre), .in_up(in_up), .in_user(in_user), .in_wb(in_wb),
        .in_load(in_load), .in_base(in_base), .in_rlist(in_rlist),
        .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_op(uop_op), .uop_dst(uop_dst), .uop_src(uop_src),
        .uop_imm(uop_imm), .uop_neg(uop_neg), .uop_last(uop_last),
        .err_mode(err_mode)
    );

    // Entry: {pre, up, wb, load, base[3:0], list[15:0]}
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd2,  16'h0013},  // R2 store
        {1'b0, 1'b1, 1'b1, 1'b1, 4'd13, 16'h8001},  // R3 load wb
        {1'b1, 1'b0, 1'b1, 1'b0, 4'd13, 16'h4030},  // R4 store wb
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  16'h0F00},  // R5 load
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd5,  16'h0000},  // R11 empty
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd7,  16'h0000},  // R11 empty wb
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  16'hFFFF},  // R2 full list
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 16'h0001}   // R5 single wb
    };

    function automatic logic [20:0] act_fields();
        return {uop_op, uop_dst, uop_src, uop_imm, uop_neg, uop_last};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [20:0] act, input logic [20:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic offer(input logic p, u, s, w, l, input logic [3:0] b,
                         input logic [15:0] rl);
        in_valid = 1'b1; in_pre = p; in_up = u; in_user = s;
        in_wb = w; in_load = l; in_base = b; in_rlist = rl;
        step();
        in_valid = 1'b0; in_user = 1'b0;
    endtask

    // Independent model of the expected stream, checked one micro-op per cycle.
    task automatic run_instr(input logic p, u, w, l, input logic [3:0] b,
                             input logic [15:0] rl, input bit stall_first);
        int n;
        int left;
        logic [6:0] off;
        logic [20:0] exp;
        string mtag;
        n = $countones(rl);
        case ({p, u})
            2'b00: begin off = 7'(4 * n - 4); mtag = "R2"; end
            2'b01: begin off = 7'd0;          mtag = "R3"; end
            2'b10: begin off = 7'(4 * n);     mtag = "R4"; end
            default: begin off = 7'd4;        mtag = "R5"; end
        endcase
        offer(p, u, 1'b0, w, l, b, rl);
        exp = {2'd0, 5'd17, {1'b0, b}, 7'd0, 1'b0, (n == 0) && !w};
        check(uop_valid && act_fields() == exp, (n == 0) ? "R1 R11" : "R1",
              act_fields(), exp);
        if (stall_first) begin
            // R12: hold under back-pressure, another instruction not taken
            uop_ready = 1'b0;
            in_valid = 1'b1; in_pre = 1'b1; in_up = 1'b0; in_wb = 1'b1;
            in_base = 4'd9; in_rlist = 16'hFFFF;
            step();
            step();
            check(uop_valid && !in_ready && act_fields() == exp, "R12",
                  act_fields(), exp);
            in_valid = 1'b0;
            uop_ready = 1'b1;
        end
        step();
        left = n;
        for (int i = 0; i < 16; i++) begin
            if (rl[i]) begin
                exp = {l ? 2'd2 : 2'd3, 5'(i), 5'd17, off, !u, (left == 1) && !w};
                check(uop_valid && act_fields() == exp, {mtag, " R6 R7"},
                      act_fields(), exp);
                off = u ? off + 7'd4 : off - 7'd4;
                left--;
                step();
            end
        end
        if (w) begin
            exp = {u ? 2'd0 : 2'd1, {1'b0, b}, {1'b0, b}, 7'(4 * n), 1'b0, 1'b1};
            check(uop_valid && act_fields() == exp, (n == 0) ? "R8 R11" : "R8",
                  act_fields(), exp);
            step();
        end
        check(!uop_valid && in_ready, "R9", {19'd0, uop_valid, in_ready},
              {19'd0, 1'b0, 1'b1});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected<=20000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!uop_valid && in_ready && !err_mode, "R12",
              {18'd0, uop_valid, in_ready, err_mode}, {18'd0, 3'b010});

        for (int v = 0; v < NV; v++) begin
            run_instr(VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20],
                      VEC[v][19:16], VEC[v][15:0], 1'b0);
        end

        // R12: stall on the copy with a competing offer
        run_instr(1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 16'h0006, 1'b1);
        step();
        check(!uop_valid && in_ready, "R12", {19'd0, uop_valid, in_ready},
              {19'd0, 2'b01});

        // R10: user-mode flag rejected
        offer(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd4, 16'h00FF);
        check(err_mode && !uop_valid, "R10", {19'd0, err_mode, uop_valid},
              {19'd0, 2'b10});
        step();
        check(!err_mode && !uop_valid && in_ready, "R10",
              {18'd0, err_mode, uop_valid, in_ready}, {18'd0, 3'b001});

        // Stream still works after a rejection
        run_instr(1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 16'h8100, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule